// File: doc/BRIEF.md
# Channel Descriptor Fetch Sequencer

This block prepares a DMA channel for its next work unit. When started, it captures the channel's register values. It then decodes the flow mode and the descriptor length from the configuration word. If the pair is legal, it reads that many 16-bit descriptor words from memory over a read port that keeps one request outstanding at a time. It writes each word into the channel register that the descriptor format assigns to it. When the last word is in, it sets up the working pointer, the working address and the working counts.

Three descriptor formats are supported. A large descriptor carries the whole next-descriptor pointer. A small descriptor carries only the pointer's low half. An array descriptor carries no pointer and is read from the current descriptor pointer rather than the next one. The stop and auto-repeat modes read nothing and go straight to initialisation. The block raises a one-cycle done pulse when it finishes, and an error flag when the request is illegal or the start address does not match the element size.

Top module: `desc_fetch_seq`

## Requirements
- R1: Flow mode is cfg[15:12] and descriptor length is cfg[11:8]. The legal pairs are: stop (0) or auto-repeat (1) with length 0; array (4) with length 1..7; small (6) with length 1..8; large (7) with length 1..9. Any other pair sets err_o, pulses done_o one cycle after the start, issues no reads and leaves every register output unchanged.
- R2: A legal start issues exactly `length` reads, one at a time. Each rd_req_o lasts a single cycle and is not repeated until rd_valid_i returns. Read k goes to base + 2k, where base is curr_desc_i in array mode and next_ptr_i in small and large mode.
- R3: Large mode loads words in this order: next pointer low, next pointer high, start address low, start address high, config, X count, X modify, Y count, Y modify.
- R4: Small mode loads the next pointer low half first. Its following words continue from start address low in the R3 order, skipping the next pointer high half.
- R5: Array mode loads its first word into start address low and continues in the R3 order from there.
- R6: On a legal start, every register that the fetched words do not reach keeps the value captured from the inputs at the start.
- R7: At completion, curr_desc_o equals the loaded next pointer and curr_addr_o equals the loaded start address.
- R8: At completion, a loaded X or Y count of zero gives a working count of 0xFFFF; any other value is copied unchanged.
- R9: The element size comes from the loaded config bits [3:2]: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, and 3 is reserved. A start address that is not a multiple of the element size, or the reserved code, sets err_o at completion.
- R10: done_o is a single-cycle pulse. It comes 1 cycle after an illegal start, and 2 + length*(1+L) cycles after a legal start when the memory answers L cycles after the request. A legal start clears err_o. After reset all outputs are zero.
- R11: A start_i while busy_o is high, and an rd_valid_i while no read is outstanding, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch/initialise sequence |
| cfg_i | input | 16 | Present config register |
| next_ptr_i | input | 32 | Present next-descriptor pointer |
| curr_desc_i | input | 32 | Present current-descriptor pointer |
| start_addr_i | input | 32 | Present start address |
| x_count_i | input | 16 | Present X count |
| x_mod_i | input | 16 | Present X modify |
| y_count_i | input | 16 | Present Y count |
| y_mod_i | input | 16 | Present Y modify |
| rd_req_o | output | 1 | Descriptor word read request |
| rd_addr_o | output | 32 | Read byte address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Configuration or alignment error |
| cfg_o | output | 16 | Loaded config |
| next_ptr_o | output | 32 | Loaded next-descriptor pointer |
| start_addr_o | output | 32 | Loaded start address |
| x_count_o | output | 16 | Loaded X count |
| x_mod_o | output | 16 | Loaded X modify |
| y_count_o | output | 16 | Loaded Y count |
| y_mod_o | output | 16 | Loaded Y modify |
| curr_desc_o | output | 32 | Working descriptor pointer |
| curr_addr_o | output | 32 | Working address |
| curr_x_o | output | 16 | Working X count |
| curr_y_o | output | 16 | Working Y count |

## Verification
Each read request appears one cycle after the start, or one cycle after the previous word is accepted. The bench memory returns data exactly L cycles after it sees a request, with L set per case to 1, 2 or 3. done_o is due 1 cycle after an illegal start and 2 + length*(1+L) cycles after a legal one. The bench compares every rd_req_o and rd_addr_o at the falling edge of each cycle against the queue of addresses its model expects. It counts cycles from the start edge to done_o and compares that count with the formula. It samples the loaded and working registers only in the done cycle, and checks in the following cycle that done_o has dropped.

// File: rtl/desc_pkg.sv
package desc_pkg;
  localparam int FLOW_LSB = 12;
  localparam int ND_LSB   = 8;
  localparam int WD_LSB   = 2;
  localparam int NSLOT    = 9;

  localparam int ARRAY_MAX = 7;
  localparam int SMALL_MAX = 8;
  localparam int LARGE_MAX = 9;

  typedef enum logic [3:0] {
    FLOW_STOP  = 4'd0,
    FLOW_AUTO  = 4'd1,
    FLOW_ARRAY = 4'd4,
    FLOW_SMALL = 4'd6,
    FLOW_LARGE = 4'd7
  } flow_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_FIN
  } seq_st_e;

  // slot positions, large-format order
  localparam int SL_NP_LO = 0;
  localparam int SL_NP_HI = 1;
  localparam int SL_SA_LO = 2;
  localparam int SL_SA_HI = 3;
  localparam int SL_CFG   = 4;
  localparam int SL_XC    = 5;
  localparam int SL_XM    = 6;
  localparam int SL_YC    = 7;
  localparam int SL_YM    = 8;
endpackage

// File: rtl/desc_decode.sv
module desc_decode
  import desc_pkg::*;
#(
  parameter int NDW = 4
) (
  input  logic [3:0]     flow_i,
  input  logic [NDW-1:0] nd_i,
  output logic           legal_o,
  output logic           is_array_o,
  output logic           is_small_o
);
  always_comb begin
    legal_o    = 1'b0;
    is_array_o = 1'b0;
    is_small_o = 1'b0;
    case (flow_i)
      FLOW_STOP, FLOW_AUTO: legal_o = (nd_i == '0);
      FLOW_ARRAY: begin
        is_array_o = 1'b1;
        legal_o    = (nd_i != '0) && (int'(nd_i) <= ARRAY_MAX);
      end
      FLOW_SMALL: begin
        is_small_o = 1'b1;
        legal_o    = (nd_i != '0) && (int'(nd_i) <= SMALL_MAX);
      end
      FLOW_LARGE: legal_o = (nd_i != '0) && (int'(nd_i) <= LARGE_MAX);
      default:    legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/desc_slot_map.sv
module desc_slot_map
  import desc_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic [SW-1:0] word_i,
  input  logic          is_array_i,
  input  logic          is_small_i,
  output logic [SW-1:0] slot_o
);
  // array skips both pointer halves, small skips only the high half
  always_comb begin
    if (is_array_i)
      slot_o = word_i + SW'(SL_SA_LO);
    else if (is_small_i && word_i != '0)
      slot_o = word_i + SW'(1);
    else
      slot_o = word_i;
  end
endmodule

// File: rtl/desc_init.sv
module desc_init #(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic [AW-1:0] next_ptr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [DW-1:0] x_cnt_i,
  input  logic [DW-1:0] y_cnt_i,
  input  logic [1:0]    wd_i,
  output logic [AW-1:0] cur_desc_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [DW-1:0] cur_x_o,
  output logic [DW-1:0] cur_y_o,
  output logic          misalign_o
);
  assign cur_desc_o = next_ptr_i;
  assign cur_addr_o = start_addr_i;
  assign cur_x_o    = (x_cnt_i == '0) ? '1 : x_cnt_i;
  assign cur_y_o    = (y_cnt_i == '0) ? '1 : y_cnt_i;

  always_comb begin
    case (wd_i)
      2'd0:    misalign_o = 1'b0;
      2'd1:    misalign_o = start_addr_i[0];
      2'd2:    misalign_o = |start_addr_i[1:0];
      default: misalign_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import desc_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NDW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DW-1:0]   cfg_i,
  input  logic [2*DW-1:0] next_ptr_i,
  input  logic [2*DW-1:0] curr_desc_i,
  input  logic [2*DW-1:0] start_addr_i,
  input  logic [DW-1:0]   x_count_i,
  input  logic [DW-1:0]   x_mod_i,
  input  logic [DW-1:0]   y_count_i,
  input  logic [DW-1:0]   y_mod_i,
  output logic            rd_req_o,
  output logic [2*DW-1:0] rd_addr_o,
  input  logic            rd_valid_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [DW-1:0]   cfg_o,
  output logic [2*DW-1:0] next_ptr_o,
  output logic [2*DW-1:0] start_addr_o,
  output logic [DW-1:0]   x_count_o,
  output logic [DW-1:0]   x_mod_o,
  output logic [DW-1:0]   y_count_o,
  output logic [DW-1:0]   y_mod_o,
  output logic [2*DW-1:0] curr_desc_o,
  output logic [2*DW-1:0] curr_addr_o,
  output logic [DW-1:0]   curr_x_o,
  output logic [DW-1:0]   curr_y_o
);
  localparam int AW = 2 * DW;
  localparam int SW = NDW;

  seq_st_e       st_q;
  logic [SW-1:0] k_q, nd_q;
  logic [AW-1:0] base_q;
  logic          arr_q, sml_q, err_q, done_q;
  logic [AW-1:0] cdesc_q, caddr_q;
  logic [DW-1:0] cx_q, cy_q;
  logic [DW-1:0] slot_q [NSLOT];
  logic [DW-1:0] init_w [NSLOT];

  logic          legal, is_arr, is_sml;
  logic [SW-1:0] slot_idx;
  logic [AW-1:0] i_desc, i_addr;
  logic [DW-1:0] i_x, i_y;
  logic          misalign;
  logic          accept, take_word;

  desc_decode #(.NDW(NDW)) u_dec (
    .flow_i    (cfg_i[FLOW_LSB +: 4]),
    .nd_i      (cfg_i[ND_LSB +: NDW]),
    .legal_o   (legal),
    .is_array_o(is_arr),
    .is_small_o(is_sml)
  );

  desc_slot_map #(.SW(SW)) u_map (
    .word_i    (k_q),
    .is_array_i(arr_q),
    .is_small_i(sml_q),
    .slot_o    (slot_idx)
  );

  desc_init #(.DW(DW)) u_init (
    .next_ptr_i  ({slot_q[SL_NP_HI], slot_q[SL_NP_LO]}),
    .start_addr_i({slot_q[SL_SA_HI], slot_q[SL_SA_LO]}),
    .x_cnt_i     (slot_q[SL_XC]),
    .y_cnt_i     (slot_q[SL_YC]),
    .wd_i        (slot_q[SL_CFG][WD_LSB +: 2]),
    .cur_desc_o  (i_desc),
    .cur_addr_o  (i_addr),
    .cur_x_o     (i_x),
    .cur_y_o     (i_y),
    .misalign_o  (misalign)
  );

  assign accept    = start_i && (st_q == S_IDLE) && legal;
  assign take_word = (st_q == S_WAIT) && rd_valid_i;

  always_comb begin
    init_w[SL_NP_LO] = next_ptr_i[DW-1:0];
    init_w[SL_NP_HI] = next_ptr_i[AW-1:DW];
    init_w[SL_SA_LO] = start_addr_i[DW-1:0];
    init_w[SL_SA_HI] = start_addr_i[AW-1:DW];
    init_w[SL_CFG]   = cfg_i;
    init_w[SL_XC]    = x_count_i;
    init_w[SL_XM]    = x_mod_i;
    init_w[SL_YC]    = y_count_i;
    init_w[SL_YM]    = y_mod_i;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slot_q[g] <= '0;
      else if (accept)
        slot_q[g] <= init_w[g];
      else if (take_word && slot_idx == SW'(g))
        slot_q[g] <= rd_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      k_q     <= '0;
      nd_q    <= '0;
      base_q  <= '0;
      arr_q   <= 1'b0;
      sml_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      cdesc_q <= '0;
      caddr_q <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            if (!legal) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              err_q  <= 1'b0;
              nd_q   <= cfg_i[ND_LSB +: NDW];
              k_q    <= '0;
              arr_q  <= is_arr;
              sml_q  <= is_sml;
              base_q <= is_arr ? curr_desc_i : next_ptr_i;
              st_q   <= (cfg_i[ND_LSB +: NDW] == '0) ? S_FIN : S_REQ;
            end
          end
        end
        S_REQ: st_q <= S_WAIT;
        S_WAIT: begin
          if (rd_valid_i) begin
            k_q  <= k_q + SW'(1);
            st_q <= (k_q + SW'(1) == nd_q) ? S_FIN : S_REQ;
          end
        end
        S_FIN: begin
          cdesc_q <= i_desc;
          caddr_q <= i_addr;
          cx_q    <= i_x;
          cy_q    <= i_y;
          err_q   <= misalign;
          done_q  <= 1'b1;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o     = (st_q == S_REQ);
  assign rd_addr_o    = base_q + AW'({k_q, 1'b0});
  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign cfg_o        = slot_q[SL_CFG];
  assign next_ptr_o   = {slot_q[SL_NP_HI], slot_q[SL_NP_LO]};
  assign start_addr_o = {slot_q[SL_SA_HI], slot_q[SL_SA_LO]};
  assign x_count_o    = slot_q[SL_XC];
  assign x_mod_o      = slot_q[SL_XM];
  assign y_count_o    = slot_q[SL_YC];
  assign y_mod_o      = slot_q[SL_YM];
  assign curr_desc_o  = cdesc_q;
  assign curr_addr_o  = caddr_q;
  assign curr_x_o     = cx_q;
  assign curr_y_o     = cy_q;

  AST_ILLEGAL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !legal) |=> (err_o && done_o && !rd_req_o && !busy_o)); // R1
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o); // R2
  AST_WORD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (k_q <= nd_q)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (curr_x_o != '0 && curr_y_o != '0)); // R8
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ($stable(nd_q) && $stable(base_q))); // R11
endmodule

// File: tb/tb_desc_fetch_seq.sv
`timescale 1ns/1ps
module tb_desc_fetch_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] cfg_i = '0;
  logic [31:0] next_ptr_i = '0, curr_desc_i = '0, start_addr_i = '0;
  logic [15:0] x_count_i = '0, x_mod_i = '0, y_count_i = '0, y_mod_i = '0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_valid_i;
  logic [15:0] rd_data_i;
  logic        busy_o, done_o, err_o;
  logic [15:0] cfg_o, x_count_o, x_mod_o, y_count_o, y_mod_o, curr_x_o, curr_y_o;
  logic [31:0] next_ptr_o, start_addr_o, curr_desc_o, curr_addr_o;

  always #2.5 clk_i = ~clk_i;

  desc_fetch_seq dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  int lat_g   = 1;
  bit stray_g = 1'b0;

  logic [15:0] e_slot [9];
  logic [31:0] e_cdesc = '0, e_caddr = '0;
  logic [15:0] e_cx = '0, e_cy = '0;
  logic        e_err = 1'b0;

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    logic [15:0] a [9];
    a[0] = next_ptr_o[15:0];   a[1] = next_ptr_o[31:16];
    a[2] = start_addr_o[15:0]; a[3] = start_addr_o[31:16];
    a[4] = cfg_o; a[5] = x_count_o; a[6] = x_mod_o; a[7] = y_count_o; a[8] = y_mod_o;
    for (int i = 0; i < 9; i++)
      chk(a[i] == e_slot[i], req, $sformatf("slot %0d", i), 32'(a[i]), 32'(e_slot[i]));
    chk(curr_desc_o == e_cdesc, "R7", "curr_desc", curr_desc_o, e_cdesc);
    chk(curr_addr_o == e_caddr, "R7", "curr_addr", curr_addr_o, e_caddr);
    chk(curr_x_o == e_cx, "R8", "curr_x", 32'(curr_x_o), 32'(e_cx));
    chk(curr_y_o == e_cy, "R8", "curr_y", 32'(curr_y_o), 32'(e_cy));
    chk(err_o == e_err, "R9", "err", 32'(err_o), 32'(e_err));
  endtask

  function automatic bit legal_pair(input logic [3:0] fl, input int nd);
    if (fl == 4'd0 || fl == 4'd1) return nd == 0;
    if (fl == 4'd4) return nd >= 1 && nd <= 7;
    if (fl == 4'd6) return nd >= 1 && nd <= 8;
    if (fl == 4'd7) return nd >= 1 && nd <= 9;
    return 1'b0;
  endfunction

  // memory: answers lat_g cycles after a sampled request
  initial begin
    int pend = 0;
    logic [31:0] pa = '0;
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk_i);
      rd_valid_i = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem_word(pa);
        end
      end else if (rd_req_o) begin
        pa   = rd_addr_o;
        pend = lat_g;
      end else if (stray_g && !busy_o) begin
        rd_valid_i = 1'b1;
        rd_data_i  = 16'hDEAD;
      end
    end
  end

  task automatic run_case(input string req, input logic [15:0] cfg,
                          input logic [31:0] np, input logic [31:0] cd,
                          input logic [31:0] sa, input logic [15:0] xc,
                          input logic [15:0] xm, input logic [15:0] yc,
                          input logic [15:0] ym, input int lat, input bit poke);
    logic [31:0] q[$];
    logic [15:0] s [9];
    int nd, exp_cyc, cyc, idx;
    bit legal, seen;
    logic [31:0] base;
    lat_g = lat;
    nd = int'(cfg[11:8]);
    legal = legal_pair(cfg[15:12], nd);
    if (legal) begin
      s[0] = np[15:0]; s[1] = np[31:16]; s[2] = sa[15:0]; s[3] = sa[31:16];
      s[4] = cfg; s[5] = xc; s[6] = xm; s[7] = yc; s[8] = ym;
      base = (cfg[15:12] == 4'd4) ? cd : np;
      for (int k = 0; k < nd; k++) begin
        q.push_back(base + 32'(2 * k));
        if (cfg[15:12] == 4'd7)      idx = k;
        else if (cfg[15:12] == 4'd6) idx = (k == 0) ? 0 : k + 1;
        else                         idx = k + 2;
        s[idx] = mem_word(base + 32'(2 * k));
      end
      for (int i = 0; i < 9; i++) e_slot[i] = s[i];
      e_cdesc = {s[1], s[0]};
      e_caddr = {s[3], s[2]};
      e_cx = (s[5] == 16'h0) ? 16'hFFFF : s[5];
      e_cy = (s[7] == 16'h0) ? 16'hFFFF : s[7];
      case (s[4][3:2])
        2'd0: e_err = 1'b0;
        2'd1: e_err = e_caddr[0];
        2'd2: e_err = e_caddr[1:0] != 2'b00;
        default: e_err = 1'b1;
      endcase
      exp_cyc = 2 + nd * (1 + lat);
    end else begin
      e_err = 1'b1;
      exp_cyc = 1;
    end
    @(negedge clk_i);
    cfg_i = cfg; next_ptr_i = np; curr_desc_i = cd; start_addr_i = sa;
    x_count_i = xc; x_mod_i = xm; y_count_i = yc; y_mod_i = ym;
    start_i = 1'b1;
    cyc = 0;
    seen = 1'b0;
    while (!seen && cyc < 400) begin
      @(negedge clk_i);
      cyc++;
      start_i = 1'b0;
      if (poke && cyc == 2) begin // R11: start while busy
        start_i = 1'b1; cfg_i = 16'h7900; next_ptr_i = 32'h0BAD_0000;
        curr_desc_i = 32'h0BAD_1000; start_addr_i = 32'h0;
      end
      if (rd_req_o) begin
        if (q.size() == 0)
          chk(1'b0, "R2", "unexpected read", rd_addr_o, 32'h0);
        else begin
          base = q.pop_front();
          chk(rd_addr_o == base, "R2", "read address", rd_addr_o, base);
        end
      end
      if (done_o) seen = 1'b1;
    end
    chk(seen && cyc == exp_cyc, "R10", "done latency", 32'(cyc), 32'(exp_cyc));
    chk(q.size() == 0, "R2", "reads missing", 32'(q.size()), 32'h0);
    if (!legal)
      chk(err_o == 1'b1, "R1", "illegal err", 32'(err_o), 32'h1);
    chk_regs(req);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R10", "done width", 32'(done_o), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) e_slot[i] = '0;
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(!busy_o && !done_o && !err_o && !rd_req_o, "R10", "reset ctrl",
        {29'h0, busy_o, done_o, err_o}, 32'h0);
    chk_regs("R10");
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_case("R3", 16'h7904, 32'h0001_0000, 32'h0, 32'h0000_4000,
             16'h1111, 16'h2222, 16'h3333, 16'h4444, 1, 1'b0);
    run_case("R4", 16'h6800, 32'h0002_0040, 32'h0, 32'h0, 16'h0, 16'h0, 16'h0, 16'h0, 3, 1'b0);
    run_case("R5", 16'h4700, 32'h0000_7000, 32'h0003_2000, 32'h0, 16'h5, 16'h1, 16'h6, 16'h2, 2, 1'b0);
    run_case("R6", 16'h6300, 32'h0004_0100, 32'h0, 32'h1234_5678,
             16'hA0A0, 16'hB1B1, 16'hC2C2, 16'hD3D3, 1, 1'b0);
    run_case("R6", 16'h7200, 32'h0005_0200, 32'h0, 32'h0000_1000,
             16'h0010, 16'h0004, 16'h0020, 16'h0008, 2, 1'b0);
    run_case("R8", 16'h0000, 32'h00AB_CDEF, 32'h0, 32'h0000_1000, 16'h0, 16'h1, 16'h0, 16'h1, 1, 1'b0);
    run_case("R7", 16'h1004, 32'h1111_2222, 32'h0, 32'h0000_2002, 16'h7, 16'h2, 16'h3, 16'h2, 1, 1'b0);
    run_case("R9", 16'h1008, 32'h0, 32'h0, 32'h0000_1002, 16'h4, 16'h4, 16'h1, 16'h4, 1, 1'b0);
    run_case("R9", 16'h0004, 32'h0, 32'h0, 32'h0000_0101, 16'h4, 16'h2, 16'h1, 16'h2, 1, 1'b0);
    run_case("R9", 16'h0000, 32'h0, 32'h0, 32'h0000_0101, 16'h4, 16'h1, 16'h1, 16'h1, 1, 1'b0);
    run_case("R9", 16'h000C, 32'h0, 32'h0, 32'h0000_1000, 16'h4, 16'h8, 16'h1, 16'h8, 1, 1'b0);
    // R1: illegal pairs
    run_case("R1", 16'h0100, 32'h0006_0000, 32'h0, 32'h0, 16'h9, 16'h9, 16'h9, 16'h9, 1, 1'b0);
    run_case("R1", 16'h4800, 32'h0006_0000, 32'h0007_0000, 32'h0, 16'h9, 16'h9, 16'h9, 16'h9, 1, 1'b0);
    run_case("R1", 16'h6900, 32'h0006_0000, 32'h0, 32'h0, 16'h9, 16'h9, 16'h9, 16'h9, 1, 1'b0);
    run_case("R1", 16'h7A00, 32'h0006_0000, 32'h0, 32'h0, 16'h9, 16'h9, 16'h9, 16'h9, 1, 1'b0);
    run_case("R1", 16'h7000, 32'h0006_0000, 32'h0, 32'h0, 16'h9, 16'h9, 16'h9, 16'h9, 1, 1'b0);
    run_case("R1", 16'h2000, 32'h0006_0000, 32'h0, 32'h0, 16'h9, 16'h9, 16'h9, 16'h9, 1, 1'b0);
    // R10: legal start after an error clears err_o
    run_case("R10", 16'h0000, 32'h0, 32'h0, 32'h0000_0040, 16'h3, 16'h1, 16'h3, 16'h1, 1, 1'b0);
    // R11: start while busy
    run_case("R11", 16'h7404, 32'h0008_0000, 32'h0, 32'h0, 16'h1, 16'h2, 16'h3, 16'h4, 2, 1'b1);
    // R11: stray read data while idle
    stray_g = 1'b1;
    repeat (6) @(negedge clk_i);
    stray_g = 1'b0;
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R11", "stray ctrl", {30'h0, busy_o, done_o}, 32'h0);
    chk_regs("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule